// File: doc/BRIEF.md
# Stepper Phase Excitation Sequencer

This block decides which of the four winding drives of a unipolar two-phase stepping motor are switched on. A slow, asynchronous step clock from elsewhere in the system sets the motor speed: every rising edge moves the excitation pattern one step. The step size is a half step in half-step mode, and one full two-coil step in full-step mode. A direction input chooses forward or reverse rotation. The current chopper and the power stage sit downstream and take the four-bit coil vector as their on/off command.

All inputs are brought into the system clock domain through synchronizer chains before use. The reset input clears the pattern asynchronously and is released in step with the system clock. One eight-entry position counter serves both step modes. Because of this, switching mode while the motor turns does not lose the rotor phase. The enable input blanks the coils without stopping the counter, so a motor that is re-enabled picks up exactly where the step clock has taken it.

Top module: `stepper_phase_seq`

## Requirements
- R1: While `rst_n` is low, `coils` is 4'b0000. After release with `enable` high and no step edge, `coils` shows A with B-bar (4'b1001). The bit order is [3]=A, [2]=A-bar, [1]=B, [0]=B-bar.
- R2: Without a rising edge on `step_clk`, `coils` holds its pattern indefinitely.
- R3: In half-step mode (`half_step`=1) with `reverse`=0, each step edge walks forward through 1001, 1000, 1010, 0010, 0110, 0100, 0101, 0001 and then wraps back to 1001.
- R4: With `reverse`=1, each step edge walks the same cycle in the opposite order.
- R5: In full-step mode (`half_step`=0), starting from a two-coil pattern, each step edge skips to the next two-coil pattern in the chosen direction. Only patterns with two coils on appear.
- R6: In full-step mode, if the current pattern has a single coil on, the next step edge moves exactly one half step in the chosen direction, onto a two-coil pattern.
- R7: A mode change keeps the current position, and stepping continues from it. A mode value that arrives together with a step clock rise governs that step.
- R8: With `enable` low, `coils` is 4'b0000. Step edges seen while disabled still advance the position, and raising `enable` shows the advanced pattern.
- R9: A and A-bar are never on together, and B and B-bar are never on together.
- R10: A step clock that stays high for many system cycles counts as exactly one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| step_clk | input | 1 | Asynchronous step clock, rising edge advances |
| half_step | input | 1 | 1: half-step mode, 0: full-step two-coil mode |
| reverse | input | 1 | 0: forward, 1: reverse |
| enable | input | 1 | 1: coils driven, 0: all coils off |
| coils | output | 4 | Coil drives {A, A-bar, B, B-bar} |

## Verification
A step clock rise can land in the same system cycle as a mode change or as an enable drop. Both cases matter: the first decides how far the counter moves, and the second decides whether a blanked step is still counted. The bench changes `half_step` or `enable` at the same instant as it raises `step_clk`, so all of them cross the equal-length synchronizers together. It then checks that the new mode sets the step size, and that the step hidden under the enable drop shows up once the coils are re-enabled. A scoreboard model of the position, kept independently of the design, predicts every pattern.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

   localparam int unsigned POS_W  = 3;
   localparam int unsigned N_POS  = 1 << POS_W;
   localparam int unsigned COIL_W = 4;

   typedef logic [POS_W-1:0]  pos_t;
   typedef logic [COIL_W-1:0] coil_t;

   // coil vector bit positions
   localparam int unsigned C_A  = 3;
   localparam int unsigned C_AN = 2;
   localparam int unsigned C_B  = 1;
   localparam int unsigned C_BN = 0;

   // even positions drive two coils, odd positions one
   function automatic logic is_dual(input pos_t p);
      return ~p[0];
   endfunction

endpackage

// File: rtl/stepseq_sync.sv
module stepseq_sync #(
   parameter int unsigned     WIDTH   = 1,
   parameter int unsigned     STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stg [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("stepseq_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) stg[0] <= RST_VAL;
               else         stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge arst_n) begin
               if (!arst_n) stg[i] <= RST_VAL;
               else         stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];

endmodule

// File: rtl/stepseq_position.sv
module stepseq_position
   import stepseq_pkg::*;
(
   input  logic clk,
   input  logic srst_n,
   input  logic step_lvl,
   input  logic half,
   input  logic rev,
   output pos_t pos,
   output logic step_evt
);

   logic step_prev;
   pos_t delta;
   pos_t pos_nx;

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) step_prev <= 1'b0;
      else         step_prev <= step_lvl;
   end

   assign step_evt = step_lvl & ~step_prev;

   // step size: one half step, or two when already aligned in full-step mode
   always_comb begin
      delta = pos_t'(1);
      if (!half && is_dual(pos)) delta = pos_t'(2);
   end

   always_comb begin
      pos_nx = pos;
      if (step_evt) pos_nx = rev ? pos_t'(pos - delta) : pos_t'(pos + delta);
   end

   always_ff @(posedge clk or negedge srst_n) begin
      if (!srst_n) pos <= '0;
      else         pos <= pos_nx;
   end

   assert_hold_R2: assert property (@(posedge clk) disable iff (!srst_n)
      !step_evt |=> $stable(pos));

   assert_half_fwd_R3: assert property (@(posedge clk) disable iff (!srst_n)
      (step_evt && half && !rev) |=> pos == pos_t'($past(pos) + pos_t'(1)));

   assert_half_rev_R4: assert property (@(posedge clk) disable iff (!srst_n)
      (step_evt && half && rev) |=> pos == pos_t'($past(pos) - pos_t'(1)));

   assert_full_aligned_R5: assert property (@(posedge clk) disable iff (!srst_n)
      (step_evt && !half) |=> !pos[0]);

   assert_realign_R6: assert property (@(posedge clk) disable iff (!srst_n)
      (step_evt && !half && pos[0] && !rev) |=> pos == pos_t'($past(pos) + pos_t'(1)));

endmodule

// File: rtl/stepseq_coil_decode.sv
module stepseq_coil_decode
   import stepseq_pkg::*;
(
   input  pos_t  pos,
   output coil_t pattern
);

   // position ring: A+Bn, A, A+B, B, An+B, An, An+Bn, Bn
   always_comb begin
      pattern = '0;
      unique case (pos)
         3'd0: begin pattern[C_A]  = 1'b1; pattern[C_BN] = 1'b1; end
         3'd1: begin pattern[C_A]  = 1'b1;                       end
         3'd2: begin pattern[C_A]  = 1'b1; pattern[C_B]  = 1'b1; end
         3'd3: begin pattern[C_B]  = 1'b1;                       end
         3'd4: begin pattern[C_AN] = 1'b1; pattern[C_B]  = 1'b1; end
         3'd5: begin pattern[C_AN] = 1'b1;                       end
         3'd6: begin pattern[C_AN] = 1'b1; pattern[C_BN] = 1'b1; end
         3'd7: begin pattern[C_BN] = 1'b1;                       end
         default: pattern = '0;
      endcase
   end

endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
   import stepseq_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step_clk,
   input  logic       half_step,
   input  logic       reverse,
   input  logic       enable,
   output logic [3:0] coils
);

   localparam int unsigned N_IN = 4;

   logic              srst_n;
   logic [N_IN-1:0]   raw_in;
   logic [N_IN-1:0]   syn_in;
   logic              step_s, half_s, rev_s, en_s;
   pos_t              pos;
   logic              step_evt;
   coil_t             pattern;
   coil_t             gated;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("stepper_phase_seq: SYNC_STAGES must be at least 2");
      end
   endgenerate

   stepseq_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
      .clk    (clk),
      .arst_n (rst_n),
      .d      (1'b1),
      .q      (srst_n)
   );

   assign raw_in = {step_clk, half_step, reverse, enable};

   stepseq_sync #(.WIDTH(N_IN), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_in_sync (
      .clk    (clk),
      .arst_n (rst_n),
      .d      (raw_in),
      .q      (syn_in)
   );

   assign {step_s, half_s, rev_s, en_s} = syn_in;

   stepseq_position u_pos (
      .clk      (clk),
      .srst_n   (srst_n),
      .step_lvl (step_s),
      .half     (half_s),
      .rev      (rev_s),
      .pos      (pos),
      .step_evt (step_evt)
   );

   stepseq_coil_decode u_dec (
      .pos     (pos),
      .pattern (pattern)
   );

   assign gated = (en_s && srst_n) ? pattern : '0;

   generate
      if (OUT_REG) begin : g_out_reg
         coil_t coils_q;
         always_ff @(posedge clk or negedge srst_n) begin
            if (!srst_n) coils_q <= '0;
            else         coils_q <= gated;
         end
         assign coils = coils_q;

         assert_blank_R8: assert property (@(posedge clk) disable iff (!srst_n)
            !en_s |=> coils == 4'b0000);
      end else begin : g_out_comb
         assign coils = gated;

         assert_blank_R8: assert property (@(posedge clk) disable iff (!srst_n)
            !en_s |-> coils == 4'b0000);
      end
   endgenerate

   assert_a_excl_R9: assert property (@(posedge clk) disable iff (!srst_n)
      !(coils[C_A] && coils[C_AN]));

   assert_b_excl_R9: assert property (@(posedge clk) disable iff (!srst_n)
      !(coils[C_B] && coils[C_BN]));

   assert_one_edge_R10: assert property (@(posedge clk) disable iff (!srst_n)
      step_evt |=> !step_evt);

endmodule

// File: tb/sim_stepper_phase_seq.sv
module sim_stepper_phase_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       step_clk = 1'b0;
   logic       half_step = 1'b1;
   logic       reverse = 1'b0;
   logic       enable = 1'b1;
   logic [3:0] coils;

   int errors = 0;
   int checks = 0;
   int mpos = 0;
   logic men = 1'b1;
   logic finished = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];
   event       chk_ev;

   always #10 clk = ~clk;

   stepper_phase_seq u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_clk  (step_clk),
      .half_step (half_step),
      .reverse   (reverse),
      .enable    (enable),
      .coils     (coils)
   );

   function automatic logic [3:0] ring(input int p);
      case (p)
         0: return 4'b1001;
         1: return 4'b1000;
         2: return 4'b1010;
         3: return 4'b0010;
         4: return 4'b0110;
         5: return 4'b0100;
         6: return 4'b0101;
         default: return 4'b0001;
      endcase
   endfunction

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_now(input logic [3:0] exp, input string tag);
      checks++;
      if (coils !== exp) begin
         errors++;
         $display("FAIL %s: coils actual=%b expected=%b", tag, coils, exp);
      end
   endtask

   task automatic expect_push(input string tag);
      exp_q.push_back(men ? ring(mpos) : 4'b0000);
      tag_q.push_back(tag);
      ->chk_ev;
      #1;
   endtask

   task automatic model_step();
      int d;
      d = (!half_step && (mpos % 2 == 0)) ? 2 : 1;
      mpos = reverse ? (mpos - d + 8) % 8 : (mpos + d) % 8;
   endtask

   task automatic step(input int high_cycles, input string tag);
      step_clk = 1'b1;
      wait_clk(high_cycles);
      step_clk = 1'b0;
      wait_clk(6);
      model_step();
      expect_push(tag);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(chk_ev);
         if (exp_q.size() != 0) begin
            logic [3:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check_now(e, t);
         end
      end
   end

   // per-cycle coil exclusivity check (R9)
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         checks++;
         if ((coils[3] && coils[2]) || (coils[1] && coils[0])) begin
            errors++;
            $display("FAIL R9: coils actual=%b expected no opposing pair", coils);
         end
      end
   end

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      wait_clk(3);
      step_clk = 1'b1; wait_clk(3); step_clk = 1'b0; wait_clk(3);
      check_now(4'b0000, "R1 during reset");
      rst_n = 1'b1;
      wait_clk(8);
      mpos = 0;
      check_now(4'b1001, "R1 after release");

      wait_clk(50);
      check_now(4'b1001, "R2 hold");

      half_step = 1'b1; reverse = 1'b0;
      for (int i = 0; i < 8; i++) step(4, "R3 half forward");

      reverse = 1'b1;
      for (int i = 0; i < 3; i++) step(4, "R4 half reverse");

      reverse = 1'b0; half_step = 1'b0;
      wait_clk(4);
      for (int i = 0; i < 4; i++) step(4, "R5 full forward");

      half_step = 1'b1; wait_clk(4);
      step(4, "R7 half keeps position");
      half_step = 1'b0; wait_clk(4);
      step(4, "R6 realign forward");
      step(4, "R5 full after realign");

      half_step = 1'b1; wait_clk(4);
      step(4, "R7 half again");
      // mode change arrives together with step rise
      half_step = 1'b0; reverse = 1'b1;
      step(4, "R6 realign reverse same-cycle mode");
      step(4, "R4 full reverse");

      // R7: switch to half in the same instant as a step rise
      reverse = 1'b0;
      half_step = 1'b1;
      step(4, "R7 same-cycle half select");

      // enable drops together with a step rise
      enable = 1'b0; men = 1'b0;
      step(4, "R8 disabled step");
      check_now(4'b0000, "R8 blanked");
      step(4, "R8 disabled step 2");
      half_step = 1'b0; wait_clk(4);
      step(4, "R8 disabled full step");
      enable = 1'b1; men = 1'b1;
      wait_clk(8);
      check_now(ring(mpos), "R8 resume advanced");

      half_step = 1'b1;
      step(40, "R10 long high single step");
      wait_clk(30);
      check_now(ring(mpos), "R10 no extra step");

      rst_n = 1'b0;
      wait_clk(2);
      check_now(4'b0000, "R1 reset mid-run");
      rst_n = 1'b1; mpos = 0;
      wait_clk(8);
      check_now(4'b1001, "R1 restart pattern");

      wait_clk(2);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule